// File: doc/BRIEF.md
# Flash Write-Completion Poll Checker

This block runs on the host side of a parallel flash interface and decides whether a program or erase operation has succeeded. It starts after the command sequence has already been written. It reads the operation address over and over through a simple request/return handshake to a bus master. On each returned byte it looks at two things: the top status bit, which it compares with the bit it expects once the operation has finished, and the timeout flag.

The timeout flag and the status bit can change in the same read. For that reason a set timeout flag never fails the operation at once. The checker first makes one confirming read. After the status bit has matched, the checker makes one further read, because the lower bits of the word are only valid on a later read than the one that showed completion. It reports that byte as the final data.

A poll budget stops a device that never answers from holding the checker forever. An erase always expects a 1 in the top bit. A program expects the top bit of the value that was written.

Top module: `poll_done_checker`

## Requirements
- R1: During and right after reset, busy_o, pass_o, fail_o and rd_req_o are 0 and final_data_o is 0.
- R2: A start_i seen while idle makes busy_o 1 from the next cycle and issues the first read request. For a program (erase_i=0), the expected completion bit is exp_bit_i, captured at start.
- R3: With erase_i=1 at start, the expected completion bit is 1 whatever the value of exp_bit_i.
- R4: When a poll read returns bit 7 equal to the expected bit, exactly one more read is issued. Its full byte appears on final_data_o in the same cycle as a one-cycle pass_o.
- R5: When a poll read returns bit 7 not equal to the expected bit and bit 5 (timeout flag) is 0, another poll read follows, provided the budget is not used up.
- R6: When a poll read mismatches on bit 7 and has bit 5 set, one re-check read is issued. A bit-7 match on that read leads to the final read and pass. A mismatch gives fail with no further reads. A match on bit 7 takes precedence over bit 5 in any poll read.
- R7: If MAX_POLLS poll reads (default 16) have all mismatched with bit 5 clear, fail_o pulses after the last of them and no further read is issued.
- R8: pass_o and fail_o are one-cycle pulses and never both 1. busy_o is 0 in the cycle a result pulses.
- R9: A start_i seen while busy has no effect on the expected bit, the read sequence or the result.
- R10: rd_req_o is a one-cycle pulse. No new request is issued until rd_valid_i has returned data for the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| erase_i | input | 1 | 1: erase (expect 1 on bit 7); 0: program |
| exp_bit_i | input | 1 | Bit 7 of the programmed datum |
| rd_req_o | output | 1 | One-cycle read request to the bus master |
| rd_valid_i | input | 1 | Read data returned this cycle |
| rd_data_i | input | DATA_W | Returned flash byte |
| busy_o | output | 1 | Operation being checked |
| pass_o | output | 1 | One-cycle pass result |
| fail_o | output | 1 | One-cycle fail result |
| final_data_o | output | DATA_W | Byte from the read after completion |

## Verification
Several read streams are used, and each one separates a different path through the checker:
- An immediate match, and a match after several busy reads, show the plain poll loop and the extra final read.
- An erase started with a program bit of 0 shows that the expected bit is forced to 1.
- A timeout flag followed by a matching read, and one followed by a mismatching read, split the confirm path into its pass and fail outcomes.
- A read with both bits set shows that a match wins over the timeout flag.

A stream that never completes exercises the poll budget. A second start pulse during a program proves that it does not re-arm the checker, since accepting it would shorten the read count. Every pattern is run with both short and long read latencies.

// File: rtl/pollchk_pkg.sv
package pollchk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLL_REQ,
        ST_POLL_WAIT,
        ST_RECHK_REQ,
        ST_RECHK_WAIT,
        ST_FINAL_REQ,
        ST_FINAL_WAIT
    } pc_state_e;

    typedef struct packed {
        logic hit;   // status bit equals expected completion value
        logic tmo;   // device timeout flag set
    } pc_status_t;

    function automatic logic is_req(input pc_state_e s);
        return (s == ST_POLL_REQ) || (s == ST_RECHK_REQ) || (s == ST_FINAL_REQ);
    endfunction

    function automatic logic is_wait(input pc_state_e s);
        return (s == ST_POLL_WAIT) || (s == ST_RECHK_WAIT) || (s == ST_FINAL_WAIT);
    endfunction

endpackage

// File: rtl/pollchk_eval.sv
module pollchk_eval
    import pollchk_pkg::*;
(
    input  logic       stat_bit_i,
    input  logic       tmo_bit_i,
    input  logic       exp_bit_i,
    output pc_status_t st_o
);

    always_comb begin
        st_o.hit = (stat_bit_i == exp_bit_i);
        st_o.tmo = tmo_bit_i;
    end

endmodule

// File: rtl/pollchk_limit.sv
module pollchk_limit #(
    parameter int MAX_POLLS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic inc_i,
    output logic at_limit_o
);

    localparam int CNT_W = $clog2(MAX_POLLS + 1);
    localparam logic [CNT_W-1:0] LIM  = CNT_W'(MAX_POLLS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_POLLS - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && cnt_q != LIM) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_limit_o = (cnt_q == LAST);

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIM);

endmodule

// File: rtl/pollchk_ctrl.sv
module pollchk_ctrl
    import pollchk_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              erase_i,
    input  logic              exp_bit_i,
    input  logic              rd_valid_i,
    input  logic [DATA_W-1:0] rd_data_i,
    input  pc_status_t        st_i,
    input  logic              at_limit_i,
    output logic              exp_q_o,
    output logic              rd_req_o,
    output logic              busy_o,
    output logic              pass_o,
    output logic              fail_o,
    output logic              cnt_clr_o,
    output logic              cnt_inc_o,
    output logic [DATA_W-1:0] final_data_o
);

    pc_state_e         state_q, state_d;
    logic              exp_q;
    logic              pass_q, pass_d, fail_q, fail_d;
    logic [DATA_W-1:0] fin_q;

    always_comb begin
        state_d   = state_q;
        pass_d    = 1'b0;
        fail_d    = 1'b0;
        cnt_clr_o = 1'b0;
        cnt_inc_o = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d   = ST_POLL_REQ;
                    cnt_clr_o = 1'b1;
                end
            end
            ST_POLL_REQ:  state_d = ST_POLL_WAIT;
            ST_POLL_WAIT: begin
                if (rd_valid_i) begin
                    cnt_inc_o = 1'b1;
                    if (st_i.hit) begin
                        state_d = ST_FINAL_REQ;
                    end else if (st_i.tmo) begin
                        state_d = ST_RECHK_REQ;
                    end else if (at_limit_i) begin
                        state_d = ST_IDLE;
                        fail_d  = 1'b1;
                    end else begin
                        state_d = ST_POLL_REQ;
                    end
                end
            end
            ST_RECHK_REQ:  state_d = ST_RECHK_WAIT;
            ST_RECHK_WAIT: begin
                if (rd_valid_i) begin
                    if (st_i.hit) begin
                        state_d = ST_FINAL_REQ;
                    end else begin
                        state_d = ST_IDLE;
                        fail_d  = 1'b1;
                    end
                end
            end
            ST_FINAL_REQ:  state_d = ST_FINAL_WAIT;
            ST_FINAL_WAIT: begin
                if (rd_valid_i) begin
                    state_d = ST_IDLE;
                    pass_d  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            exp_q   <= 1'b0;
            pass_q  <= 1'b0;
            fail_q  <= 1'b0;
            fin_q   <= '0;
        end else begin
            state_q <= state_d;
            pass_q  <= pass_d;
            fail_q  <= fail_d;
            if (state_q == ST_IDLE && start_i) begin
                exp_q <= erase_i | exp_bit_i;
            end
            if (state_q == ST_FINAL_WAIT && rd_valid_i) begin
                fin_q <= rd_data_i;
            end
        end
    end

    assign exp_q_o      = exp_q;
    assign rd_req_o     = is_req(state_q);
    assign busy_o       = (state_q != ST_IDLE);
    assign pass_o       = pass_q;
    assign fail_o       = fail_q;
    assign final_data_o = fin_q;

    // R10
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req_o |=> !rd_req_o);

    // R10
    no_req_while_waiting_chk: assert property (@(posedge clk) disable iff (rst)
        (is_wait(state_q) && !rd_valid_i) |=> !rd_req_o);

    // R8
    pass_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        pass_o |=> !pass_o);

    // R8
    fail_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        fail_o |=> !fail_o);

    // R8
    result_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (pass_o || fail_o) |-> !busy_o);

    // R9
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> $stable(exp_q));

endmodule

// File: rtl/poll_done_checker.sv
module poll_done_checker
    import pollchk_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int STAT_BIT  = 7,
    parameter int TMO_BIT   = 5,
    parameter int MAX_POLLS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              erase_i,
    input  logic              exp_bit_i,
    output logic              rd_req_o,
    input  logic              rd_valid_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              busy_o,
    output logic              pass_o,
    output logic              fail_o,
    output logic [DATA_W-1:0] final_data_o
);

    pc_status_t st;
    logic       exp_q;
    logic       at_limit, cnt_clr, cnt_inc;

    pollchk_eval u_eval (
        .stat_bit_i (rd_data_i[STAT_BIT]),
        .tmo_bit_i  (rd_data_i[TMO_BIT]),
        .exp_bit_i  (exp_q),
        .st_o       (st)
    );

    pollchk_limit #(.MAX_POLLS(MAX_POLLS)) u_limit (
        .clk        (clk),
        .rst        (rst),
        .clr_i      (cnt_clr),
        .inc_i      (cnt_inc),
        .at_limit_o (at_limit)
    );

    pollchk_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .erase_i      (erase_i),
        .exp_bit_i    (exp_bit_i),
        .rd_valid_i   (rd_valid_i),
        .rd_data_i    (rd_data_i),
        .st_i         (st),
        .at_limit_i   (at_limit),
        .exp_q_o      (exp_q),
        .rd_req_o     (rd_req_o),
        .busy_o       (busy_o),
        .pass_o       (pass_o),
        .fail_o       (fail_o),
        .cnt_clr_o    (cnt_clr),
        .cnt_inc_o    (cnt_inc),
        .final_data_o (final_data_o)
    );

    // R8
    one_result_chk: assert property (@(posedge clk) disable iff (rst)
        !(pass_o && fail_o));

    // R4
    pass_after_return_chk: assert property (@(posedge clk) disable iff (rst)
        pass_o |-> $past(rd_valid_i));

endmodule

// File: tb/test_poll_done_checker.sv
`timescale 1ns/1ps
module test_poll_done_checker;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0, erase_i = 1'b0, exp_bit_i = 1'b0;
    logic       rd_valid_i = 1'b0;
    logic [7:0] rd_data_i = 8'h00;
    logic       rd_req_o, busy_o, pass_o, fail_o;
    logic [7:0] final_data_o;

    always #2.5 clk = ~clk;

    poll_done_checker i_poll_done_checker (
        .clk(clk), .rst(rst), .start_i(start_i), .erase_i(erase_i),
        .exp_bit_i(exp_bit_i), .rd_req_o(rd_req_o), .rd_valid_i(rd_valid_i),
        .rd_data_i(rd_data_i), .busy_o(busy_o), .pass_o(pass_o),
        .fail_o(fail_o), .final_data_o(final_data_o)
    );

    int n_chk = 0, n_fail = 0;
    logic [7:0] rsp_q[$];
    int rsp_lat = 1, rsp_cnt = 0, n_req = 0;
    bit model_on = 0, seen_pass = 0, seen_fail = 0;
    bit e_busy = 0, e_pass = 0, e_fail = 0, m_exp = 0;
    logic [7:0] e_final = 8'h00;
    int m_mode = 0, m_polls = 0;   // mode 0 poll, 1 re-check, 2 final read
    localparam int MAXP = 16;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (model_on) begin
            chk(busy_o == e_busy, "R2 busy", busy_o, e_busy);
            chk(pass_o == e_pass, "R4 pass pulse", pass_o, e_pass);
            chk(fail_o == e_fail, "R8 fail pulse", fail_o, e_fail);
            chk(final_data_o == e_final, "R4 final data", final_data_o, e_final);
        end
        // memory responder
        rd_valid_i = 1'b0;
        if (rsp_cnt > 0) begin
            rsp_cnt--;
            if (rsp_cnt == 0) begin
                rd_valid_i = 1'b1;
                rd_data_i  = (rsp_q.size() > 0) ? rsp_q.pop_front() : 8'h00;
            end
        end
        if (rd_req_o) begin
            chk(rsp_cnt == 0, "R10 request while outstanding", rsp_cnt, 0);
            rsp_cnt = rsp_lat;
            n_req++;
        end
        if (pass_o) seen_pass = 1;
        if (fail_o) seen_fail = 1;
        // reference model: next expected outputs
        e_pass = 0;
        e_fail = 0;
        if (start_i && !e_busy) begin
            e_busy  = 1;
            m_exp   = erase_i ? 1'b1 : exp_bit_i;
            m_polls = 0;
            m_mode  = 0;
        end else if (rd_valid_i && e_busy) begin
            if (m_mode == 0) begin
                m_polls++;
                if (rd_data_i[7] == m_exp) m_mode = 2;
                else if (rd_data_i[5]) m_mode = 1;
                else if (m_polls >= MAXP) begin e_fail = 1; e_busy = 0; end
            end else if (m_mode == 1) begin
                if (rd_data_i[7] == m_exp) m_mode = 2;
                else begin e_fail = 1; e_busy = 0; end
            end else begin
                e_pass = 1; e_busy = 0; e_final = rd_data_i;
            end
        end
    end

    task automatic run_op(input bit er, input bit ex, input int lat, input bit poke,
                          input bit want_pass, input int want_reads,
                          input logic [7:0] want_fin, input string tag);
        rsp_lat = lat;
        seen_pass = 0; seen_fail = 0; n_req = 0;
        @(posedge clk); #1;
        erase_i = er; exp_bit_i = ex; start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0; erase_i = 1'b0; exp_bit_i = ~ex;
        if (poke) begin
            repeat (3) @(posedge clk);
            #1 start_i = 1'b1; erase_i = 1'b1; exp_bit_i = 1'b1;
            @(posedge clk); #1 start_i = 1'b0; erase_i = 1'b0;
        end
        while (!(seen_pass || seen_fail)) @(negedge clk);
        chk(seen_pass == want_pass, {tag, " outcome"}, seen_pass, want_pass);
        chk(n_req == want_reads, {tag, " read count"}, n_req, want_reads);
        if (want_pass) chk(final_data_o == want_fin, {tag, " final byte"}, final_data_o, want_fin);
        repeat (3) @(posedge clk);
        chk(rd_req_o == 1'b0 && busy_o == 1'b0, {tag, " idle after result"}, rd_req_o, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({busy_o, pass_o, fail_o, rd_req_o} == 4'b0, "R1 reset outputs",
            {busy_o, pass_o, fail_o, rd_req_o}, 0);
        chk(final_data_o == 8'h00, "R1 reset final", final_data_o, 0);
        @(posedge clk); #1 rst = 1'b0; model_on = 1;
        @(negedge clk);
        chk(busy_o == 1'b0, "R1 idle after reset", busy_o, 0);

        for (int lat = 1; lat <= 3; lat += 2) begin
            rsp_q = '{8'hA5, 8'hA5};
            run_op(0, 1, lat, 0, 1, 2, 8'hA5, "R2 R4 immediate match");
            rsp_q = '{8'hC3, 8'hC3, 8'h3C, 8'h3C};
            run_op(0, 0, lat, 0, 1, 4, 8'h3C, "R5 busy reads then match");
            rsp_q = '{8'h00, 8'h00, 8'hFF, 8'hFF};
            run_op(1, 0, lat, 0, 1, 4, 8'hFF, "R3 erase expects one");
            rsp_q = '{8'h20, 8'hA0, 8'hFF};
            run_op(0, 1, lat, 0, 1, 3, 8'hFF, "R6 timeout then match");
            rsp_q = '{8'h20, 8'h20};
            run_op(0, 1, lat, 0, 0, 2, 8'h00, "R6 timeout then mismatch");
            rsp_q = '{8'h00, 8'h00, 8'h20, 8'h20};
            run_op(0, 1, lat, 0, 0, 4, 8'h00, "R6 late timeout fail");
            rsp_q = '{8'hA0, 8'h7E};
            run_op(0, 1, lat, 0, 1, 2, 8'h7E, "R6 match beats timeout");
            rsp_q = {};
            for (int i = 0; i < MAXP; i++) rsp_q.push_back(8'h00);
            run_op(0, 1, lat, 0, 0, MAXP, 8'h00, "R7 poll budget");
            rsp_q = '{8'h80, 8'h80, 8'h80, 8'h00, 8'h5A};
            run_op(0, 0, lat, 1, 1, 5, 8'h5A, "R9 start while busy");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule